// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command-register front end of a 16-bit NOR-style memory. It watches a synchronous write port: one write per cycle in which `wr_en` is high, carrying an address and a data word. It recognises the interlocked multi-write command sequences that change what the memory does. Each sequence opens with two unlock writes. The write after them selects word program, chip erase, the ID-read (autoselect) view or the secured-sector view. The decoder also follows a one-write reset command, and a wrong write at any point drops it back to plain array reading.

The decoder keeps the current read view on `mode_o`. In the ID-read view it supplies the identification words on `id_word`. When a program or erase command completes, it sends a one-cycle start pulse to an external program/erase sequencer, together with the captured target address and data. While that sequencer reports `busy`, every write is ignored. An `accel` input lets a program set-up write be accepted without the two unlock writes.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A low `rst_n` sampled at a clock edge puts `mode_o` at 0 (array view), clears any partial sequence and keeps both start pulses low.
- R2: An unlock pair is data 00AAh with address low 12 bits 555h, then data 0055h with address low 12 bits 2AAh. Only the low 12 address bits are compared for unlock and command writes, and data is compared on all 16 bits.
- R3: Unlock pair, then 00A0h at 555h, then one more write at any address makes `prog_start` high for exactly the cycle after that last write. At the same time `op_addr` and `op_data` hold that write's address and data.
- R4: Unlock pair, 0080h at 555h, a second unlock pair, then 0010h at 555h makes `erase_start` high for exactly the cycle after the sixth write.
- R5: Unlock pair then 0090h at 555h sets `mode_o` to 1 (ID view). In that view `id_word` for address low byte 00h is 00C2h, for 01h is 22FDh and for 03h is 0088h (0048h when FACTORY_LOCKED is 0), and for any other offset it is 0000h. Outside the ID view `id_word` is 0000h.
- R6: A write of 00F0h at any address returns `mode_o` to 0 and clears any partial sequence. The one exception is the data write of a program sequence, where 00F0h is program data.
- R7: A write that does not match the expected next unlock or command write aborts the sequence and sets `mode_o` to 0.
- R8: While `busy` is high, a write changes nothing: `mode_o`, the sequence position and the start pulses are unaffected.
- R9: With `accel` high and no sequence in progress, a write of 00A0h at 555h is taken as program set-up, and the next write starts a program as in R3.
- R10: Unlock pair then 0088h at 555h sets `mode_o` to 2 (secured view). In the secured view, unlock pair, 0090h at 555h and then 0000h at any address set `mode_o` to 0.
- R11: `prog_start` and `erase_start` are never high together, and each stays high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | A write is present this cycle |
| addr | input | ADDR_W (21) | Write or read address |
| wdata | input | DATA_W (16) | Write data |
| busy | input | 1 | Program/erase sequencer is working |
| accel | input | 1 | Accept program set-up without unlock writes |
| mode_o | output | 2 | Read view: 0 array, 1 ID, 2 secured |
| id_word | output | DATA_W (16) | Identification word for the current address |
| prog_start | output | 1 | One-cycle program start pulse |
| erase_start | output | 1 | One-cycle chip erase start pulse |
| op_addr | output | ADDR_W (21) | Captured program address |
| op_data | output | DATA_W (16) | Captured program data |

## Verification
The assertions assume that `busy` only rises after a start pulse and that `rst_n` is low for at least one edge before the first write. The stimulus drives `busy` as a free random flag on single writes, so the "ignored while busy" checks look only at the write they accompany. Random writes are drawn from the command codes and the two unlock addresses, with random upper address bits. Half of them are steered to the correct next write of the sequence in progress, so that long program, erase and secured-exit sequences occur alongside random aborts.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_UNL1  = 3'd1,
        SQ_UNL2  = 3'd2,
        SQ_PDATA = 3'd3,
        SQ_ER0   = 3'd4,
        SQ_ER1   = 3'd5,
        SQ_ER2   = 3'd6,
        SQ_SXIT  = 3'd7
    } seq_e;

    typedef enum logic [1:0] {
        MD_ARRAY   = 2'd0,
        MD_IDREAD  = 2'd1,
        MD_SECURE  = 2'd2
    } rmode_e;

    typedef enum logic [3:0] {
        CD_AA, CD_55, CD_A0, CD_80, CD_90, CD_88, CD_10, CD_00, CD_F0, CD_OTHER
    } code_e;

    localparam logic [11:0] UNLOCK_ADR_A = 12'h555;
    localparam logic [11:0] UNLOCK_ADR_B = 12'h2AA;

    localparam logic [15:0] ID_MAKER   = 16'h00C2;
    localparam logic [15:0] ID_PART    = 16'h22FD;
    localparam logic [15:0] ID_LOCKED  = 16'h0088;
    localparam logic [15:0] ID_OPEN    = 16'h0048;

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify #(
    parameter int CMP_W  = 12,
    parameter int DATA_W = 16
) (
    input  logic [CMP_W-1:0]  lo_addr,
    input  logic [DATA_W-1:0] data,
    output logic              at_a,
    output logic              at_b,
    output fcd_pkg::code_e    code
);
    import fcd_pkg::*;

    localparam logic [CMP_W-1:0] ADR_A = CMP_W'(UNLOCK_ADR_A);
    localparam logic [CMP_W-1:0] ADR_B = CMP_W'(UNLOCK_ADR_B);

    assign at_a = (lo_addr == ADR_A);
    assign at_b = (lo_addr == ADR_B);

    always_comb begin
        case (data)
            DATA_W'(16'h00AA): code = CD_AA;
            DATA_W'(16'h0055): code = CD_55;
            DATA_W'(16'h00A0): code = CD_A0;
            DATA_W'(16'h0080): code = CD_80;
            DATA_W'(16'h0090): code = CD_90;
            DATA_W'(16'h0088): code = CD_88;
            DATA_W'(16'h0010): code = CD_10;
            DATA_W'(16'h0000): code = CD_00;
            DATA_W'(16'h00F0): code = CD_F0;
            default:           code = CD_OTHER;
        endcase
    end

endmodule

// File: rtl/fcd_id_words.sv
module fcd_id_words #(
    parameter int DATA_W         = 16,
    parameter int OFS_W          = 8,
    parameter bit FACTORY_LOCKED = 1'b1
) (
    input  logic              enable,
    input  logic [OFS_W-1:0]  offset,
    output logic [DATA_W-1:0] word
);
    import fcd_pkg::*;

    logic [DATA_W-1:0] indicator;

    generate
        if (FACTORY_LOCKED) begin : g_locked
            assign indicator = DATA_W'(ID_LOCKED);
        end else begin : g_open
            assign indicator = DATA_W'(ID_OPEN);
        end
    endgenerate

    always_comb begin
        word = '0;
        if (enable) begin
            case (offset)
                OFS_W'(0): word = DATA_W'(ID_MAKER);
                OFS_W'(1): word = DATA_W'(ID_PART);
                OFS_W'(3): word = indicator;
                default:   word = '0;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W         = 21,
    parameter int DATA_W         = 16,
    parameter int CMP_W          = 12,
    parameter int OFS_W          = 8,
    parameter bit FACTORY_LOCKED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic              accel,
    output logic [1:0]        mode_o,
    output logic [DATA_W-1:0] id_word,
    output logic              prog_start,
    output logic              erase_start,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);
    import fcd_pkg::*;

    typedef struct packed {
        seq_e              st;
        rmode_e            md;
        logic              go_prog;
        logic              go_erase;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] d;
    } regs_t;

    regs_t  r_d, r_q;
    logic   at_a, at_b;
    code_e  cd;
    seq_e   st_q;

    fcd_classify #(.CMP_W(CMP_W), .DATA_W(DATA_W)) u_cls (
        .lo_addr (addr[CMP_W-1:0]),
        .data    (wdata),
        .at_a    (at_a),
        .at_b    (at_b),
        .code    (cd)
    );

    fcd_id_words #(.DATA_W(DATA_W), .OFS_W(OFS_W), .FACTORY_LOCKED(FACTORY_LOCKED)) u_ids (
        .enable (r_q.md == MD_IDREAD),
        .offset (addr[OFS_W-1:0]),
        .word   (id_word)
    );

    always_comb begin
        r_d          = r_q;
        r_d.go_prog  = 1'b0;
        r_d.go_erase = 1'b0;
        if (wr_en && !busy) begin
            // Default outcome of any write: sequence ends; mismatches also drop the view.
            r_d.st = SQ_IDLE;
            unique case (r_q.st)
                SQ_IDLE: begin
                    if (at_a && cd == CD_AA)                r_d.st = SQ_UNL1;
                    else if (accel && at_a && cd == CD_A0)  r_d.st = SQ_PDATA;
                    else                                    r_d.md = MD_ARRAY;
                end
                SQ_UNL1: begin
                    if (at_b && cd == CD_55) r_d.st = SQ_UNL2;
                    else                     r_d.md = MD_ARRAY;
                end
                SQ_UNL2: begin
                    if (at_a && cd == CD_A0)      r_d.st = SQ_PDATA;
                    else if (at_a && cd == CD_80) r_d.st = SQ_ER0;
                    else if (at_a && cd == CD_90) begin
                        if (r_q.md == MD_SECURE) r_d.st = SQ_SXIT;
                        else                     r_d.md = MD_IDREAD;
                    end
                    else if (at_a && cd == CD_88) r_d.md = MD_SECURE;
                    else                          r_d.md = MD_ARRAY;
                end
                SQ_PDATA: begin
                    r_d.go_prog = 1'b1;
                    r_d.a       = addr;
                    r_d.d       = wdata;
                end
                SQ_ER0: begin
                    if (at_a && cd == CD_AA) r_d.st = SQ_ER1;
                    else                     r_d.md = MD_ARRAY;
                end
                SQ_ER1: begin
                    if (at_b && cd == CD_55) r_d.st = SQ_ER2;
                    else                     r_d.md = MD_ARRAY;
                end
                SQ_ER2: begin
                    if (at_a && cd == CD_10) r_d.go_erase = 1'b1;
                    else                     r_d.md = MD_ARRAY;
                end
                SQ_SXIT: begin
                    // 0000h completes the exit; any other write aborts: both land in array view
                    r_d.md = MD_ARRAY;
                end
                default: r_d.md = MD_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= SQ_IDLE;
            r_q.md       <= MD_ARRAY;
            r_q.go_prog  <= 1'b0;
            r_q.go_erase <= 1'b0;
            r_q.a        <= '0;
            r_q.d        <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_q        = r_q.st;
    assign mode_o      = r_q.md;
    assign prog_start  = r_q.go_prog;
    assign erase_start = r_q.go_erase;
    assign op_addr     = r_q.a;
    assign op_data     = r_q.d;

endmodule

// File: rtl/fcd_chk.sv
module fcd_chk #(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              busy,
    input logic [1:0]        mode_o,
    input logic [DATA_W-1:0] id_word,
    input logic              prog_start,
    input logic              erase_start,
    input fcd_pkg::seq_e     st
);
    import fcd_pkg::*;

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mode_o == 2'd0 && st == SQ_IDLE && !prog_start && !erase_start));

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prog_start, erase_start}));

    // R11
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start || erase_start) |=> !(prog_start || erase_start));

    // R3
    prog_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(wr_en && !busy && st == SQ_PDATA));

    // R4
    erase_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> $past(wr_en && !busy && st == SQ_ER2 && wdata == DATA_W'(16'h0010)));

    // R5
    id_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 2'd1) |-> (id_word == '0));

    // R6
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wdata == DATA_W'(16'h00F0) && st != SQ_PDATA)
        |=> (mode_o == 2'd0 && st == SQ_IDLE));

    // R7
    unlock_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && st == SQ_UNL1 && (addr[11:0] != 12'h2AA || wdata != DATA_W'(16'h0055)))
        |=> (mode_o == 2'd0 && st == SQ_IDLE));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mode_o) && $stable(st) && !prog_start && !erase_start));

    // R10
    secure_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && st == SQ_SXIT) |=> (mode_o == 2'd0));

    // R5
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);

endmodule

bind flash_cmd_decoder fcd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .busy        (busy),
    .mode_o      (mode_o),
    .id_word     (id_word),
    .prog_start  (prog_start),
    .erase_start (erase_start),
    .st          (st_q)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [20:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        busy = 1'b0;
    logic        accel = 1'b0;
    logic [1:0]  mode_o;
    logic [15:0] id_word;
    logic        prog_start, erase_start;
    logic [20:0] op_addr;
    logic [15:0] op_data;

    int total = 0;
    int bad = 0;

    // bench reference: sequence step and read view
    int m_st = 0;
    int m_md = 0;
    bit e_prog, e_er;
    logic [20:0] e_a;
    logic [15:0] e_d;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .busy(busy), .accel(accel), .mode_o(mode_o), .id_word(id_word),
        .prog_start(prog_start), .erase_start(erase_start),
        .op_addr(op_addr), .op_data(op_data)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_id(input int md, input logic [7:0] ofs);
        if (md != 1) return 16'h0000;
        case (ofs)
            8'h00:   return 16'h00C2;
            8'h01:   return 16'h22FD;
            8'h03:   return 16'h0088;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic model(input logic [20:0] a, input logic [15:0] d, input bit bz, input bit ac);
        bit pa, pb;
        int nx;
        e_prog = 0;
        e_er = 0;
        if (bz) return;
        pa = (a[11:0] == 12'h555);
        pb = (a[11:0] == 12'h2AA);
        nx = -1;  // -1 means abort to array view
        case (m_st)
            0: if (pa && d == 16'h00AA) nx = 1;
               else if (ac && pa && d == 16'h00A0) nx = 3;
            1: if (pb && d == 16'h0055) nx = 2;
            2: if (pa && d == 16'h00A0) nx = 3;
               else if (pa && d == 16'h0080) nx = 4;
               else if (pa && d == 16'h0090) begin
                   if (m_md == 2) nx = 7; else begin nx = 0; m_md = 1; end
               end
               else if (pa && d == 16'h0088) begin nx = 0; m_md = 2; end
            3: begin nx = 0; e_prog = 1; e_a = a; e_d = d; end
            4: if (pa && d == 16'h00AA) nx = 5;
            5: if (pb && d == 16'h0055) nx = 6;
            6: if (pa && d == 16'h0010) begin nx = 0; e_er = 1; end
            default: nx = -1;  // state 7: exit or abort, both array
        endcase
        if (nx < 0) begin m_st = 0; m_md = 0; end
        else m_st = nx;
    endtask

    task automatic wr(input logic [20:0] a, input logic [15:0] d, input bit bz, input bit ac,
                      input string tag);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; busy = bz; accel = ac;
        @(negedge clk);
        wr_en = 1'b0; busy = 1'b0; accel = 1'b0;
        model(a, d, bz, ac);
        chk({30'd0, mode_o}, m_md, {tag, " mode"});
        chk({31'd0, prog_start}, {31'd0, e_prog}, {tag, " prog_start"});
        chk({31'd0, erase_start}, {31'd0, e_er}, {tag, " erase_start"});
        if (e_prog) begin
            chk({11'd0, op_addr}, {11'd0, e_a}, {tag, " op_addr"});
            chk({16'd0, op_data}, {16'd0, e_d}, {tag, " op_data"});
        end
    endtask

    task automatic idchk(input logic [20:0] a, input string tag);
        @(negedge clk);
        addr = a;
        #1;
        chk({16'd0, id_word}, {16'd0, exp_id(m_md, a[7:0])}, tag);
    endtask

    task automatic unlock(input string tag);
        wr(21'h000555, 16'h00AA, 0, 0, tag);
        wr(21'h0002AA, 16'h0055, 0, 0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_md = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        logic [15:0] codes [10];
        codes = '{16'h00AA, 16'h0055, 16'h00A0, 16'h0080, 16'h0090,
                  16'h0088, 16'h0010, 16'h0000, 16'h00F0, 16'h1234};
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({30'd0, mode_o}, 0, "R1 mode after reset");
        chk({30'd0, prog_start, erase_start}, 0, "R1 pulses after reset");
        idchk(21'h000000, "R5 id quiet in array view");

        // R3 word program, upper address bits don't care on unlock (R2)
        wr(21'h1F0555, 16'h00AA, 0, 0, "R2 unlock upper bits");
        wr(21'h0A02AA, 16'h0055, 0, 0, "R2 unlock second");
        wr(21'h000555, 16'h00A0, 0, 0, "R3 setup");
        wr(21'h12345A, 16'hBEEF, 0, 0, "R3 data");
        // R6 exception: F0 as program data
        unlock("R6 prog");
        wr(21'h000555, 16'h00A0, 0, 0, "R6 setup");
        wr(21'h000777, 16'h00F0, 0, 0, "R6 F0 is program data");

        // R4 chip erase
        unlock("R4 a");
        wr(21'h000555, 16'h0080, 0, 0, "R4 80");
        unlock("R4 b");
        wr(21'h000555, 16'h0010, 0, 0, "R4 10");
        // R7 abort at last erase write
        unlock("R7 a");
        wr(21'h000555, 16'h0080, 0, 0, "R7 80");
        unlock("R7 b");
        wr(21'h000555, 16'h0030, 0, 0, "R7 wrong last");

        // R5 ID view
        unlock("R5");
        wr(21'h000555, 16'h0090, 0, 0, "R5 enter");
        idchk(21'h1FFF00, "R5 maker word");
        idchk(21'h000001, "R5 part word");
        idchk(21'h000003, "R5 indicator word");
        idchk(21'h000002, "R5 other offset");
        // R8 busy: F0 ignored, view stays
        wr(21'h000000, 16'h00F0, 1, 0, "R8 F0 while busy");
        idchk(21'h000001, "R8 view kept");
        // R6 reset command leaves ID view
        wr(21'h0ABCDE, 16'h00F0, 0, 0, "R6 F0");
        idchk(21'h000000, "R6 id quiet after F0");

        // R6 reset mid sequence then second write has no effect
        wr(21'h000555, 16'h00AA, 0, 0, "R6 mid a");
        wr(21'h000555, 16'h00F0, 0, 0, "R6 mid F0");
        wr(21'h0002AA, 16'h0055, 0, 0, "R6 stray 55");
        wr(21'h000555, 16'h0090, 0, 0, "R6 no ID entry");

        // R7 wrong unlock address
        wr(21'h000555, 16'h00AA, 0, 0, "R7 u1");
        wr(21'h0002AB, 16'h0055, 0, 0, "R7 bad addr");

        // R8 busy during program data
        unlock("R8");
        wr(21'h000555, 16'h00A0, 0, 0, "R8 setup");
        wr(21'h000100, 16'h5555, 1, 0, "R8 data while busy");
        wr(21'h000101, 16'h6666, 0, 0, "R8 data after busy");

        // R9 accelerated program
        wr(21'h000555, 16'h00A0, 0, 1, "R9 setup");
        wr(21'h00ABCD, 16'h0F0F, 0, 0, "R9 data");
        wr(21'h000555, 16'h00A0, 0, 0, "R9 no accel aborts");

        // R10 secured view enter / exit
        unlock("R10 a");
        wr(21'h000555, 16'h0088, 0, 0, "R10 enter");
        unlock("R10 b");
        wr(21'h000555, 16'h0090, 0, 0, "R10 90");
        chk({30'd0, mode_o}, 2, "R10 still secured before 00");
        wr(21'h000000, 16'h0000, 0, 0, "R10 exit");
        // R1 reset clears secured view and partial sequence
        unlock("R1 sec");
        wr(21'h000555, 16'h0088, 0, 0, "R1 enter secured");
        unlock("R1 partial");
        do_reset();
        chk({30'd0, mode_o}, 0, "R1 mode after mid reset");
        wr(21'h000555, 16'h0090, 0, 0, "R1 partial cleared");

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [20:0] a;
            logic [15:0] d;
            bit bz, ac;
            logic [8:0] up;
            up = 9'($urandom);
            bz = ($urandom % 8) == 0;
            ac = ($urandom % 8) == 0;
            if ($urandom % 2) begin
                case (m_st)
                    0, 4: begin a = {up, 12'h555}; d = 16'h00AA; end
                    1, 5: begin a = {up, 12'h2AA}; d = 16'h0055; end
                    2: begin
                        a = {up, 12'h555};
                        case ($urandom % 4)
                            0: d = 16'h00A0;
                            1: d = 16'h0080;
                            2: d = 16'h0090;
                            default: d = 16'h0088;
                        endcase
                    end
                    6: begin a = {up, 12'h555}; d = 16'h0010; end
                    7: begin a = 21'($urandom); d = 16'h0000; end
                    default: begin a = 21'($urandom); d = 16'($urandom); end
                endcase
            end else begin
                d = codes[$urandom % 10];
                case ($urandom % 3)
                    0: a = {up, 12'h555};
                    1: a = {up, 12'h2AA};
                    default: a = 21'($urandom);
                endcase
            end
            wr(a, d, bz, ac, "R2-R11 random");
            if ((i % 16) == 0) idchk({up, 4'h0, 8'($urandom % 4)}, "R5 random id");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule